// File: doc/BRIEF.md
# Big-Endian Byte-Lane Load/Store Unit

This block sits between a processor core and a memory that is one 32-bit word wide, with one write enable per byte. For each request the core gives a base register value, a signed 16-bit displacement, an access size (one byte or one full word), a store-or-load flag and store data. The block adds the base and the displacement to form a byte address. It turns that address into a word index and lane controls for the memory in the same cycle.

Bytes are numbered big-endian inside a word: byte offset 0 is the most significant byte. A store of one byte copies the low byte of the store data onto every lane and enables only the addressed lane. A load of one byte picks the addressed byte from the word that the memory returns one cycle later and sign-extends it. A word access whose address is not a multiple of four is flagged as misaligned and never reaches the memory.

Top module: `bytelane_lsu`

## Requirements
- R1: The effective byte address is `base_addr` plus `addr_ofs` sign-extended to 32 bits. `mem_addr` carries its bits 31:2 in the cycle of the request.
- R2: `misalign` is high in the request cycle exactly when a word access (`req_size`=1) has effective address bits 1:0 not equal to zero. Byte accesses (`req_size`=0) are never misaligned.
- R3: A misaligned request keeps `mem_en` low and `mem_we` at zero, produces no `load_valid`, and leaves memory contents unchanged.
- R4: An aligned word store drives `mem_we`=4'b1111 and `mem_wdata`=`store_data`.
- R5: A byte store drives `store_data[7:0]` onto all four lanes of `mem_wdata` and sets exactly one `mem_we` bit. `mem_we[i]` enables `mem_wdata[8i+7:8i]`, and byte offset k enables `mem_we[3-k]`: offset 0 maps to bits 31:24 and offset 3 maps to bits 7:0.
- R6: A load never sets any `mem_we` bit. An aligned load raises `mem_en` in the request cycle and raises `load_valid` in the following cycle.
- R7: A byte load at offset k returns bits [31-8k:24-8k] of the word the memory returns, sign-extended to 32 bits.
- R8: A word load returns the word the memory returns, unchanged.
- R9: During and right after reset `load_valid` is low, and with no request `mem_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 1 | 1 = word, 0 = byte |
| base_addr | input | 32 | Base register value |
| addr_ofs | input | 16 | Signed displacement |
| store_data | input | 32 | Register value to store |
| misalign | output | 1 | Misaligned word access flag |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 4 | Per-lane write enables |
| mem_addr | output | 30 | Word index |
| mem_wdata | output | 32 | Lane-positioned write data |
| mem_rdata | input | 32 | Word returned by memory, one cycle after `mem_en` |
| load_valid | output | 1 | Load result valid |
| load_data | output | 32 | Extended load result |

## Verification
The only state the block holds is the pending-load register: the valid bit, the byte offset and the size. A wrong value in any of these shows at the ports in the very next cycle. It appears as a missing or extra `load_valid`, or as a load result taken from the wrong lane or extended to the wrong width. Faults in the address, lane and misalignment paths have no memory, so they show in the request cycle itself on `mem_addr`, `mem_we`, `mem_wdata` or `misalign`. Stored data is also read back later through loads, so a lane that was written by mistake or skipped shows up as a wrong byte in a later result.

// File: rtl/blsu_pkg.sv
package blsu_pkg;
   typedef enum logic {
      SZ_BYTE = 1'b0,
      SZ_WORD = 1'b1
   } acc_size_e;

   typedef struct packed {
      logic       is_word;
      logic [1:0] lane_ofs;
   } pend_load_t;
endpackage

// File: rtl/blsu_agen.sv
module blsu_agen #(
   parameter int ADDR_W = 32,
   parameter int OFS_W  = 16,
   parameter int LANES  = 4,
   localparam int OB    = $clog2(LANES),
   localparam int WA_W  = ADDR_W - OB
) (
   input  logic              req_valid,
   input  logic              is_word,
   input  logic [ADDR_W-1:0] base_addr,
   input  logic [OFS_W-1:0]  addr_ofs,
   output logic [WA_W-1:0]   word_addr,
   output logic [OB-1:0]     lane_ofs,
   output logic              misalign
);
   localparam int EXT_W = ADDR_W - OFS_W;

   logic [ADDR_W-1:0] ofs_ext;
   logic [ADDR_W-1:0] eff_addr;

   generate
      if (OFS_W >= ADDR_W) begin : g_bad_ofs
         $error("blsu_agen: OFS_W must be smaller than ADDR_W");
      end
      if (LANES < 2) begin : g_bad_lanes
         $error("blsu_agen: LANES must be at least 2");
      end
   endgenerate

   assign ofs_ext   = {{EXT_W{addr_ofs[OFS_W-1]}}, addr_ofs};
   assign eff_addr  = base_addr + ofs_ext;
   assign word_addr = eff_addr[ADDR_W-1:OB];
   assign lane_ofs  = eff_addr[OB-1:0];
   assign misalign  = req_valid && is_word && (lane_ofs != '0);
endmodule

// File: rtl/blsu_store_lanes.sv
module blsu_store_lanes #(
   parameter int DATA_W = 32,
   localparam int LANES = DATA_W / 8,
   localparam int OB    = $clog2(LANES)
) (
   input  logic              wr_go,
   input  logic              is_word,
   input  logic [OB-1:0]     lane_ofs,
   input  logic [DATA_W-1:0] store_data,
   output logic [LANES-1:0]  lane_we,
   output logic [DATA_W-1:0] lane_wdata
);
   genvar gi;
   generate
      for (gi = 0; gi < LANES; gi++) begin : g_lane
         localparam int BE_OFS = LANES - 1 - gi;
         logic hit;
         assign hit = (lane_ofs == OB'(BE_OFS));
         assign lane_we[gi] = wr_go && (is_word || hit);
         assign lane_wdata[8*gi +: 8] = is_word ? store_data[8*gi +: 8]
                                                : store_data[7:0];
      end
   endgenerate
endmodule

// File: rtl/blsu_load_extract.sv
module blsu_load_extract #(
   parameter int DATA_W   = 32,
   parameter bit SIGN_EXT = 1'b1,
   localparam int LANES   = DATA_W / 8,
   localparam int OB      = $clog2(LANES)
) (
   input  logic              is_word,
   input  logic [OB-1:0]     lane_ofs,
   input  logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] result
);
   logic [7:0]        be_byte [LANES];
   logic [7:0]        picked;
   logic [DATA_W-1:0] byte_ext;

   genvar gk;
   generate
      for (gk = 0; gk < LANES; gk++) begin : g_pick
         assign be_byte[gk] = rdata[DATA_W-1-8*gk -: 8];
      end
      if (SIGN_EXT) begin : g_sext
         assign byte_ext = {{(DATA_W-8){picked[7]}}, picked};
      end else begin : g_zext
         assign byte_ext = {{(DATA_W-8){1'b0}}, picked};
      end
   endgenerate

   assign picked = be_byte[lane_ofs];
   assign result = is_word ? rdata : byte_ext;
endmodule

// File: rtl/bytelane_lsu.sv
module bytelane_lsu #(
   parameter int ADDR_W   = 32,
   parameter int OFS_W    = 16,
   parameter int DATA_W   = 32,
   parameter bit SIGN_EXT = 1'b1,
   localparam int LANES   = DATA_W / 8,
   localparam int OB      = $clog2(LANES),
   localparam int WA_W    = ADDR_W - OB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_store,
   input  logic              req_size,
   input  logic [ADDR_W-1:0] base_addr,
   input  logic [OFS_W-1:0]  addr_ofs,
   input  logic [DATA_W-1:0] store_data,
   output logic              misalign,
   output logic              mem_en,
   output logic [LANES-1:0]  mem_we,
   output logic [WA_W-1:0]   mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              load_valid,
   output logic [DATA_W-1:0] load_data
);
   import blsu_pkg::*;

   generate
      if (DATA_W % 8 != 0) begin : g_bad_dw
         $error("bytelane_lsu: DATA_W must be a multiple of 8");
      end
      if ((1 << OB) != LANES) begin : g_bad_pow
         $error("bytelane_lsu: lane count must be a power of two");
      end
   endgenerate

   acc_size_e         size_e;
   logic              is_word;
   logic [OB-1:0]     lane_ofs;
   logic              go;
   logic              wr_go;
   logic              rd_go;
   logic              pend_valid;
   logic              pend_word;
   logic [OB-1:0]     pend_ofs;

   assign size_e  = acc_size_e'(req_size);
   assign is_word = (size_e == SZ_WORD);

   blsu_agen #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .LANES(LANES)) i_agen (
      .req_valid (req_valid),
      .is_word   (is_word),
      .base_addr (base_addr),
      .addr_ofs  (addr_ofs),
      .word_addr (mem_addr),
      .lane_ofs  (lane_ofs),
      .misalign  (misalign)
   );

   assign go     = req_valid && !misalign;
   assign wr_go  = go && req_store;
   assign rd_go  = go && !req_store;
   assign mem_en = go;

   blsu_store_lanes #(.DATA_W(DATA_W)) i_store (
      .wr_go      (wr_go),
      .is_word    (is_word),
      .lane_ofs   (lane_ofs),
      .store_data (store_data),
      .lane_we    (mem_we),
      .lane_wdata (mem_wdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_valid <= 1'b0;
         pend_word  <= 1'b0;
         pend_ofs   <= '0;
      end else begin
         pend_valid <= rd_go;
         if (rd_go) begin
            pend_word <= is_word;
            pend_ofs  <= lane_ofs;
         end
      end
   end

   blsu_load_extract #(.DATA_W(DATA_W), .SIGN_EXT(SIGN_EXT)) i_extract (
      .is_word  (pend_word),
      .lane_ofs (pend_ofs),
      .rdata    (mem_rdata),
      .result   (load_data)
   );

   assign load_valid = pend_valid;
endmodule

// File: rtl/blsu_checker.sv
module blsu_checker #(
   parameter int DATA_W = 32,
   localparam int LANES = DATA_W / 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_store,
   input logic              req_size,
   input logic [DATA_W-1:0] store_data,
   input logic              misalign,
   input logic              mem_en,
   input logic [LANES-1:0]  mem_we,
   input logic [DATA_W-1:0] mem_wdata,
   input logic              load_valid
);
   // R2: byte accesses are never flagged
   a_r2_byte_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_size) |-> !misalign);

   // R3: a flagged access does not reach memory
   a_r3_misalign_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && misalign) |-> (mem_we == '0 && !mem_en));

   // R4: aligned word store uses every lane with data unchanged
   a_r4_word_all_lanes: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_store && req_size && !misalign) |->
         (&mem_we && mem_wdata == store_data));

   // R5: byte store touches exactly one lane
   a_r5_byte_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_store && !req_size) |-> ($countones(mem_we) == 1));

   // R6: loads never write
   a_r6_load_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_store) |-> (mem_we == '0));

   // R6: aligned load gives a result next cycle
   a_r6_load_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_store && !misalign) |=> load_valid);

   // R6: no result without an aligned load before it
   a_r6_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
      load_valid |-> $past(req_valid && !req_store && !misalign));

   // R9: idle cycles leave memory disabled
   a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |-> !mem_en);
endmodule

bind bytelane_lsu blsu_checker #(.DATA_W(DATA_W)) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_store  (req_store),
   .req_size   (req_size),
   .store_data (store_data),
   .misalign   (misalign),
   .mem_en     (mem_en),
   .mem_we     (mem_we),
   .mem_wdata  (mem_wdata),
   .load_valid (load_valid)
);

// File: tb/test_bytelane_lsu.sv
module test_bytelane_lsu;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_store = 1'b0;
   logic        req_size = 1'b0;
   logic [31:0] base_addr = '0;
   logic [15:0] addr_ofs = '0;
   logic [31:0] store_data = '0;
   logic        misalign;
   logic        mem_en;
   logic [3:0]  mem_we;
   logic [29:0] mem_addr;
   logic [31:0] mem_wdata;
   logic [31:0] mem_rdata = '0;
   logic        load_valid;
   logic [31:0] load_data;

   int checks = 0;
   int failures = 0;
   int cycles = 0;
   bit done = 1'b0;

   logic [31:0] mem_model [64];
   logic [7:0]  shadow [256];
   logic [31:0] exp_q [$];
   string       tag_q [$];

   always #2 clk = ~clk;

   bytelane_lsu i_bytelane_lsu (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
      .req_size(req_size), .base_addr(base_addr), .addr_ofs(addr_ofs),
      .store_data(store_data), .misalign(misalign), .mem_en(mem_en),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .load_valid(load_valid), .load_data(load_data)
   );

   // synchronous memory with per-lane enables
   always @(posedge clk) begin
      if (mem_en) begin
         for (int i = 0; i < 4; i++)
            if (mem_we[i]) mem_model[mem_addr[5:0]][8*i +: 8] <= mem_wdata[8*i +: 8];
         mem_rdata <= mem_model[mem_addr[5:0]];
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && load_valid) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R3/R6 unexpected load_valid", 32'd1, 32'd0);
         end else begin
            automatic logic [31:0] e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            chk(load_data === e, t, load_data, e);
         end
      end
   end

   task automatic access(input bit st, input bit wd, input logic [31:0] base,
                         input logic [15:0] ofs, input logic [31:0] sd,
                         input string tag);
      logic [31:0] ea;
      bit          mis;
      logic [7:0]  wa;
      logic [3:0]  exp_we;
      logic [31:0] exp_wd;
      @(negedge clk);
      ea  = base + {{16{ofs[15]}}, ofs};
      mis = wd && (ea[1:0] != 2'b00);
      wa  = {ea[7:2], 2'b00};
      req_valid = 1'b1; req_store = st; req_size = wd;
      base_addr = base; addr_ofs = ofs; store_data = sd;
      #1;
      chk(misalign === mis, {"R2 misalign ", tag}, {31'd0, misalign}, {31'd0, mis});
      chk(mem_en === !mis, {"R3/R6 mem_en ", tag}, {31'd0, mem_en}, {31'd0, !mis});
      if (!mis)
         chk(mem_addr === ea[31:2], {"R1 mem_addr ", tag}, {2'b0, mem_addr}, {2'b0, ea[31:2]});
      if (mis) begin
         chk(mem_we === 4'b0, {"R3 mem_we ", tag}, {28'd0, mem_we}, 32'd0);
      end else if (!st) begin
         chk(mem_we === 4'b0, {"R6 load mem_we ", tag}, {28'd0, mem_we}, 32'd0);
         if (wd) exp_q.push_back({shadow[wa], shadow[wa+1], shadow[wa+2], shadow[wa+3]});
         else    exp_q.push_back({{24{shadow[ea[7:0]][7]}}, shadow[ea[7:0]]});
         tag_q.push_back(wd ? {"R8 word load ", tag} : {"R7 byte load ", tag});
      end else if (wd) begin
         chk(mem_we === 4'hF, {"R4 mem_we ", tag}, {28'd0, mem_we}, 32'hF);
         chk(mem_wdata === sd, {"R4 mem_wdata ", tag}, mem_wdata, sd);
         for (int k = 0; k < 4; k++) shadow[wa + k] = sd[31-8*k -: 8];
      end else begin
         exp_we = 4'b1000 >> ea[1:0];
         exp_wd = {4{sd[7:0]}};
         chk(mem_we === exp_we, {"R5 mem_we ", tag}, {28'd0, mem_we}, {28'd0, exp_we});
         chk(mem_wdata === exp_wd, {"R5 mem_wdata ", tag}, mem_wdata, exp_wd);
         shadow[ea[7:0]] = sd[7:0];
      end
   endtask

   task automatic idle();
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   initial begin
      for (int i = 0; i < 64; i++) mem_model[i] = '0;
      for (int i = 0; i < 256; i++) shadow[i] = '0;
      repeat (3) @(negedge clk);
      chk(load_valid === 1'b0, "R9 load_valid in reset", {31'd0, load_valid}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(load_valid === 1'b0, "R9 load_valid after reset", {31'd0, load_valid}, 32'd0);
      chk(mem_en === 1'b0, "R9 mem_en idle", {31'd0, mem_en}, 32'd0);

      access(1, 1, 32'h0, 16'h0, 32'h80A1B2C3, "st w0");
      access(1, 1, 32'h8, 16'h8, 32'h7F00FF01, "st w10");
      access(0, 1, 32'h0, 16'h0, 32'h0, "ld w0");
      access(0, 1, 32'h10, 16'h0, 32'h0, "ld w10");
      for (int k = 0; k < 4; k++) access(0, 0, 32'h0, 16'(k), 32'h0, "ld b0x");
      for (int k = 0; k < 4; k++) access(0, 0, 32'h10, 16'(k), 32'h0, "ld b1x");
      for (int k = 0; k < 4; k++)
         access(1, 0, 32'h20, 16'(k), 32'hABCDEF00 | 32'(8'h11 * (k + 1)), "st b2x");
      access(0, 1, 32'h20, 16'h0, 32'h0, "ld w20 after bytes");
      access(1, 0, 32'h10, 16'h3, 32'hFFFFFF55, "st b13");
      access(0, 1, 32'h10, 16'h0, 32'h0, "ld w10 after b13");
      access(1, 1, 32'h20, 16'h2, 32'hDEADBEEF, "st w22 misaligned");
      access(1, 1, 32'h21, 16'h0, 32'hDEADBEEF, "st w21 misaligned");
      access(0, 1, 32'h20, 16'h0, 32'h0, "ld w20 untouched");
      access(0, 1, 32'h0, 16'h1, 32'h0, "ld w01 misaligned");
      access(0, 1, 32'h3, 16'h0, 32'h0, "ld w03 misaligned");
      access(1, 1, 32'h100, 16'hFFF0, 32'h13579BDF, "st w neg ofs");
      access(0, 1, 32'hE0, 16'h10, 32'h0, "ld w F0");
      access(0, 0, 32'hF4, 16'hFFFC, 32'h0, "ld b F0 neg ofs");
      access(0, 1, 32'h12345670, 16'h7FF0, 32'h0, "ld w high addr");
      access(0, 0, 32'hFFFFFFFF, 16'h0002, 32'h0, "ld b wrap");
      idle();
      repeat (4) @(negedge clk);
      chk(exp_q.size() == 0, "R6 results outstanding", exp_q.size(), 32'd0);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 5000 && !done) begin
         failures++;
         checks++;
         $display("FAIL watchdog actual=%08h expected=%08h", cycles, 5000);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule